// File: doc/BRIEF.md
# Readback Conversion Sequencer

This block runs one analog readback measurement per request. A bus write to the convert register arrives as a single-cycle start strobe together with a 3-bit channel code. The block turns that code into select values for a two-level analog multiplexer. The first level is a 4:1 stage over the field-current points. The second level is an 8:1 stage over the direct output voltages and the first-level result.

Once the selects are applied, the block waits a programmable settling time. It then pulls the active-low start-of-conversion line to the ADC for a programmable number of cycles and waits for end-of-conversion. The end-of-conversion input is asynchronous. It passes through a synchronizer and is detected on its edge. On that edge the ADC word is latched into the readback register and the busy flag drops.

The busy flag is meant to be mapped to bit 0 of the status word. A start strobe that arrives while busy is high is dropped without any trace. A synchronous soft reset input, like the hardware reset, returns the block to idle at once.

Top module: `rbk_conv_seq`

## Requirements
- R1: After hardware reset, busy is 0, adc_soc_n is 1, mux1_sel and mux2_sel are 0 and rbk_data is 0.
- R2: A start_stb sampled high while busy is 0 sets busy on that same clock edge, and the multiplexer selects for start_chan appear on that edge too.
- R3: Channel code decode. Codes 0 to 3 give mux2_sel equal to the code and mux1_sel = 0. Codes 4 to 7 give mux1_sel equal to the code minus 4 and mux2_sel = FIRST_LVL_PORT (default 4).
- R4: adc_soc_n goes low exactly SETTLE_CYC clock edges after the edge that accepted the start.
- R5: adc_soc_n stays low for exactly SOC_CYC cycles, then returns high. It is low only while busy is 1.
- R6: After adc_soc_n returns high, a rising edge on adc_eoc stores adc_data into rbk_data and clears busy. Both happen on the third rising clock edge after adc_eoc changes (two synchronizer stages plus the edge register).
- R7: A start_stb while busy is 1 is ignored: the selects, busy and the conversion timing are unchanged.
- R8: An adc_eoc edge outside the end-of-conversion wait (while settling, while start is active, or while idle) does not change rbk_data or busy. Each conversion captures exactly once.
- R9: soft_rst sampled high returns the block to idle on that edge: busy 0, adc_soc_n 1, both selects 0. rbk_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset to idle |
| start_stb | input | 1 | One-cycle conversion request from the register write |
| start_chan | input | 3 | Readback channel code (low bits of the written word) |
| adc_eoc | input | 1 | Asynchronous end-of-conversion from the ADC, active high |
| adc_data | input | DATA_W | ADC parallel result |
| mux1_sel | output | 2 | First-level (field current) multiplexer select |
| mux2_sel | output | 3 | Second-level multiplexer select |
| adc_soc_n | output | 1 | Active-low start-of-conversion pulse |
| busy | output | 1 | Conversion in progress (status bit 0) |
| rbk_data | output | DATA_W | Last captured conversion result |

## Verification
The assertions assume several things about the inputs. start_stb is synchronous to clk. adc_data is stable from the adc_eoc edge until the capture three edges later. adc_eoc returns low between conversions, so that every capture comes from a fresh rising edge. The bench drives every input on the falling clock edge. It holds adc_data fixed while it raises adc_eoc, and it lowers adc_eoc again before it starts the next conversion. When the bench raises adc_eoc early on purpose, it lowers it before the wait begins, so each genuine capture comes from a new edge.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_SOC    = 2'd2,
      ST_WAIT   = 2'd3
   } rbk_state_e;

   localparam int unsigned CHAN_W = 3;
   localparam int unsigned SEL1_W = 2;
   localparam int unsigned SEL2_W = 3;

endpackage

// File: rtl/rbk_edge_sync.sv
module rbk_edge_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic evt
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rbk_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], din};
         prev_q <= sh_q[STAGES-1];
      end
   end

   if (RISING) begin : g_rise
      assign evt = sh_q[STAGES-1] & ~prev_q;
   end else begin : g_fall
      assign evt = ~sh_q[STAGES-1] & prev_q;
   end

   // R8
   single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt)
      else $error("edge event lasted more than one cycle");

endmodule

// File: rtl/rbk_cycle_timer.sv
module rbk_cycle_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   if (CNT_W < 1) begin : g_bad_w
      $error("rbk_cycle_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

   // R4
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt_q == $past(load_val)))
      else $error("timer did not take its load value");

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("timer skipped a step");

endmodule

// File: rtl/rbk_chan_decode.sv
module rbk_chan_decode
   import rbk_pkg::*;
#(
   parameter int unsigned FIRST_LVL_PORT = 4
) (
   input  logic [CHAN_W-1:0] chan,
   output logic [SEL1_W-1:0] sel1,
   output logic [SEL2_W-1:0] sel2
);

   if (FIRST_LVL_PORT < 4 || FIRST_LVL_PORT > 7) begin : g_bad_port
      $error("rbk_chan_decode: FIRST_LVL_PORT must lie in 4..7");
   end

   always_comb begin
      if (chan[2]) begin
         sel1 = chan[1:0];
         sel2 = SEL2_W'(FIRST_LVL_PORT);
      end else begin
         sel1 = '0;
         sel2 = {1'b0, chan[1:0]};
      end
   end

   // R3
   always_comb begin
      sel_range_chk: assert (chan[2] || sel2 < 3'd4)
         else $error("direct channel decoded onto first-level port");
   end

endmodule

// File: rtl/rbk_conv_seq.sv
module rbk_conv_seq
   import rbk_pkg::*;
#(
   parameter int unsigned DATA_W         = 14,
   parameter int unsigned SETTLE_CYC     = 20,
   parameter int unsigned SOC_CYC        = 2,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          EOC_RISING     = 1'b1,
   parameter int unsigned FIRST_LVL_PORT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              start_stb,
   input  logic [2:0]        start_chan,
   input  logic              adc_eoc,
   input  logic [DATA_W-1:0] adc_data,
   output logic [1:0]        mux1_sel,
   output logic [2:0]        mux2_sel,
   output logic              adc_soc_n,
   output logic              busy,
   output logic [DATA_W-1:0] rbk_data
);

   localparam int unsigned MAX_CYC = (SETTLE_CYC > SOC_CYC) ? SETTLE_CYC : SOC_CYC;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("rbk_conv_seq: SETTLE_CYC must be at least 1");
   end
   if (SOC_CYC < 1) begin : g_bad_soc
      $error("rbk_conv_seq: SOC_CYC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("rbk_conv_seq: DATA_W must be positive");
   end

   rbk_state_e         state_q, state_nxt;
   logic               eoc_evt;
   logic               tmr_load;
   logic [CNT_W-1:0]   tmr_val;
   logic               tmr_done;
   logic [SEL1_W-1:0]  dec_sel1;
   logic [SEL2_W-1:0]  dec_sel2;
   logic               accept;
   logic               capture;

   rbk_edge_sync #(
      .STAGES (SYNC_STAGES),
      .RISING (EOC_RISING)
   ) u_eoc_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (adc_eoc),
      .evt   (eoc_evt)
   );

   rbk_cycle_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   rbk_chan_decode #(
      .FIRST_LVL_PORT (FIRST_LVL_PORT)
   ) u_decode (
      .chan (start_chan),
      .sel1 (dec_sel1),
      .sel2 (dec_sel2)
   );

   assign accept  = (state_q == ST_IDLE) && start_stb && !soft_rst;
   assign capture = (state_q == ST_WAIT) && eoc_evt && !soft_rst;

   always_comb begin
      state_nxt = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_stb) begin
               state_nxt = ST_SETTLE;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(SETTLE_CYC - 1);
            end
         end
         ST_SETTLE: begin
            if (tmr_done) begin
               state_nxt = ST_SOC;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(SOC_CYC - 1);
            end
         end
         ST_SOC: begin
            if (tmr_done) begin
               state_nxt = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (eoc_evt) begin
               state_nxt = ST_IDLE;
            end
         end
         default: state_nxt = ST_IDLE;
      endcase
      if (soft_rst) begin
         state_nxt = ST_IDLE;
         tmr_load  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         busy      <= 1'b0;
         adc_soc_n <= 1'b1;
      end else begin
         state_q   <= state_nxt;
         busy      <= (state_nxt != ST_IDLE);
         adc_soc_n <= (state_nxt != ST_SOC);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mux1_sel <= '0;
         mux2_sel <= '0;
      end else if (soft_rst) begin
         mux1_sel <= '0;
         mux2_sel <= '0;
      end else if (accept) begin
         mux1_sel <= dec_sel1;
         mux2_sel <= dec_sel2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbk_data <= '0;
      end else if (capture) begin
         rbk_data <= adc_data;
      end
   end

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_stb && !busy && !soft_rst) |=> busy)
      else $error("accepted start did not raise busy");

   // R7
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> ($stable(mux1_sel) && $stable(mux2_sel)))
      else $error("selects moved during a conversion");

   // R5
   soc_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_soc_n |-> busy)
      else $error("start-of-conversion low while idle");

   // R6
   result_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rbk_data) |-> $fell(busy))
      else $error("result changed without ending a conversion");

   // R9
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy && adc_soc_n && mux1_sel == '0 && mux2_sel == '0))
      else $error("soft reset did not return to idle");

endmodule

// File: tb/rbk_conv_seq_tb.sv
`timescale 1ns/1ps
module rbk_conv_seq_tb;

   localparam int DATA_W = 14;
   localparam int SETTLE = 20;
   localparam int SOCLEN = 2;
   localparam int NVEC   = 8;

   localparam logic [2:0]        V_CHAN [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
   localparam logic [1:0]        V_SEL1 [NVEC] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
   localparam logic [2:0]        V_SEL2 [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd4, 3'd4};
   localparam logic [DATA_W-1:0] V_DATA [NVEC] = '{14'h1555, 14'h2AAA, 14'h3FFF, 14'h0001,
                                                   14'h2000, 14'h0F0F, 14'h30C3, 14'h0000};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_rst = 1'b0;
   logic              start_stb = 1'b0;
   logic [2:0]        start_chan = '0;
   logic              adc_eoc = 1'b0;
   logic [DATA_W-1:0] adc_data = '0;
   logic [1:0]        mux1_sel;
   logic [2:0]        mux2_sel;
   logic              adc_soc_n;
   logic              busy;
   logic [DATA_W-1:0] rbk_data;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rbk_conv_seq u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .start_stb  (start_stb),
      .start_chan (start_chan),
      .adc_eoc    (adc_eoc),
      .adc_data   (adc_data),
      .mux1_sel   (mux1_sel),
      .mux2_sel   (mux2_sel),
      .adc_soc_n  (adc_soc_n),
      .busy       (busy),
      .rbk_data   (rbk_data)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic issue_start(input logic [2:0] ch);
      @(negedge clk);
      start_stb  = 1'b1;
      start_chan = ch;
      @(negedge clk);
      start_stb  = 1'b0;
   endtask

   // send an end-of-conversion edge and check the capture three edges later
   task automatic finish_conv(input logic [DATA_W-1:0] d, input int was_idle,
                              input logic [DATA_W-1:0] prev);
      adc_data = d;
      adc_eoc  = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (!was_idle) check("R6 busy before capture edge", busy, 1);
      @(posedge clk);
      @(negedge clk);
      check("R6 busy after capture", busy, 0);
      if (was_idle) check("R8 idle edge keeps result", rbk_data, prev);
      else          check("R6 captured data", rbk_data, d);
      adc_eoc = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_conv(input int i);
      int cnt;
      issue_start(V_CHAN[i]);
      check("R2 busy after start", busy, 1);
      check("R3 mux1_sel", mux1_sel, V_SEL1[i]);
      check("R3 mux2_sel", mux2_sel, V_SEL2[i]);
      cnt = 0;
      while (adc_soc_n && cnt < 1000) begin
         @(negedge clk);
         cnt++;
      end
      check("R4 settle cycles", cnt, SETTLE);
      cnt = 0;
      while (!adc_soc_n && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      check("R5 soc low cycles", cnt, SOCLEN);
      issue_start(~V_CHAN[i]);
      check("R7 mux1 held", mux1_sel, V_SEL1[i]);
      check("R7 mux2 held", mux2_sel, V_SEL2[i]);
      check("R7 busy held", busy, 1);
      finish_conv(V_DATA[i], 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 soc_n", adc_soc_n, 1);
      check("R1 mux1", mux1_sel, 0);
      check("R1 mux2", mux2_sel, 0);
      check("R1 result", rbk_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         run_conv(i);
      end

      // R8: early end-of-conversion during settling is ignored
      issue_start(3'd6);
      adc_data = 14'h0AAA;
      adc_eoc  = 1'b1;
      repeat (5) @(negedge clk);
      check("R8 busy after early eoc", busy, 1);
      check("R8 result after early eoc", rbk_data, V_DATA[NVEC-1]);
      adc_eoc = 1'b0;
      cnt = 0;
      while (adc_soc_n && cnt < 1000) begin
         @(negedge clk);
         cnt++;
      end
      while (!adc_soc_n && cnt < 2000) begin
         @(negedge clk);
         cnt++;
      end
      repeat (2) @(negedge clk);
      check("R8 still waiting", busy, 1);
      finish_conv(14'h1234, 0, '0);
      // R8: edge while idle leaves the result alone
      finish_conv(14'h3333, 1, 14'h1234);

      // R9: soft reset in the middle of settling
      issue_start(3'd5);
      repeat (3) @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      check("R9 busy", busy, 0);
      check("R9 soc_n", adc_soc_n, 1);
      check("R9 mux1", mux1_sel, 0);
      check("R9 mux2", mux2_sel, 0);
      check("R9 result kept", rbk_data, 14'h1234);
      repeat (SETTLE + 4) @(negedge clk);
      check("R9 no soc after reset", adc_soc_n, 1);
      run_conv(5);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule